// File: doc/BRIEF.md
# Oscillator Calibration Code Generator

This block sets the capacitor-select code of one on-chip LC-style oscillator in a single step. On a start request it opens a measurement window of a fixed number of system clocks. During that window it counts the rising edges of the oscillator under calibration and of a companion reference oscillator. It then forms the signed difference of the two counts, relative to the difference expected under typical conditions. A small writable table maps that difference to a signed correction. The correction is added to a nominal code, and the result drives a 10-bit binary-weighted capacitor bank.

One copy of the block is placed next to each oscillator. Software or a boot sequencer loads the table once, using the nominal counts expected for the process. The block then runs a calibration whenever `start_i` is pulsed. There is no search loop: one measurement yields one code update, which raises or lowers the capacitance according to the sign and size of the difference. A one-cycle `done_o` pulse marks the cycle in which the new code appears on `code_o`. The code then holds until the next calibration completes.

Top module: `osc_cal_top`

## Requirements
- R1: A start pulse accepted while idle clears both edge counts. The block then counts the rising edges of `osc_cal_i` and `osc_ref_i` seen during the next `WIN_CYC` (default 256) clock cycles. A count is exact when every high and low phase of the oscillator input lasts at least 2 clock cycles.
- R2: The difference is d = (cal count − ref count) − (`NOM_CAL_CNT` − `NOM_REF_CNT`), with a default nominal offset of 8. It is saturated to the range −8 to +7, and the table address is d + 8 (0 to 15).
- R3: The table has 16 signed 11-bit two's-complement entries, all zero after reset. A cycle with `tbl_we_i` high writes `tbl_data_i` to entry `tbl_addr_i`, and the new value is used by every later lookup.
- R4: The new code is `NOM_CODE` (default 512) plus the selected entry, clamped to the range 0 to 1023.
- R5: `done_o` is high for exactly one cycle. The rising clock edge that sets it is `WIN_CYC` + 2 edges after the edge that accepted the start, and `code_o` takes its new value on that same edge.
- R6: After reset `code_o` is 512 and `done_o` is 0. `code_o` changes only on an edge that raises `done_o`.
- R7: A start pulse that arrives while a calibration is in progress is ignored. It neither restarts the window nor shifts the completion cycle.
- R8: Bit k of `code_o` enables 2^k unit capacitors, so code 0 selects no capacitance and the 1023 non-zero codes select distinct capacitance values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-calibration pulse |
| osc_cal_i | input | 1 | Oscillator under calibration, asynchronous |
| osc_ref_i | input | 1 | Reference oscillator, asynchronous |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 4 | Table write address |
| tbl_data_i | input | 11 | Table write data, signed |
| done_o | output | 1 | One-cycle pulse: new code valid |
| code_o | output | 10 | Binary-weighted capacitor-select code |

## Verification
The hardest cases to reach are the saturated table addresses and the clamped code ends. Reaching them needs edge counts far from nominal inside a single window, together with table entries large enough to push the sum past 0 or 1023. The stimulus drives each oscillator with a chosen number of 4-cycle periods. These edges fall strictly inside the window, so the counts are known exactly. The runs move the difference below −8, above +7 and to points in between. A start pulse injected halfway through a window confirms that the completion cycle stays where the model puts it.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_CALC  = 2'd2,
    ST_APPLY = 2'd3
  } cal_state_e;
endpackage

// File: rtl/osc_edge_counter.sv
module osc_edge_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [2:0]       sync_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], osc_i};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (en_i && rise) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0)); // R1
endmodule

// File: rtl/osc_diff_lut.sv
module osc_diff_lut #(
  parameter int CNT_W   = 9,
  parameter int TBL_AW  = 4,
  parameter int ENTRY_W = 11,
  parameter int NOM_OFS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [TBL_AW-1:0]         waddr_i,
  input  logic signed [ENTRY_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]          cnt_cal_i,
  input  logic [CNT_W-1:0]          cnt_ref_i,
  output logic signed [ENTRY_W-1:0] entry_o
);
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int DIFF_W    = CNT_W + 2;
  localparam logic signed [DIFF_W-1:0] OFS_S = DIFF_W'(NOM_OFS);
  localparam logic signed [DIFF_W-1:0] LO_S  = DIFF_W'(-(TBL_DEPTH / 2));
  localparam logic signed [DIFF_W-1:0] HI_S  = DIFF_W'(TBL_DEPTH / 2 - 1);

  logic signed [ENTRY_W-1:0] tbl_q [TBL_DEPTH];
  logic signed [DIFF_W-1:0]  diff_s;
  logic signed [DIFF_W-1:0]  sat_s;
  logic [TBL_AW-1:0]         raddr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TBL_DEPTH; i++) tbl_q[i] <= '0;
    end else if (we_i) begin
      tbl_q[waddr_i] <= wdata_i;
    end
  end

  always_comb begin
    diff_s = $signed({2'b00, cnt_cal_i}) - $signed({2'b00, cnt_ref_i}) - OFS_S;
    if (diff_s < LO_S)      sat_s = LO_S;
    else if (diff_s > HI_S) sat_s = HI_S;
    else                    sat_s = diff_s;
    raddr = TBL_AW'(sat_s - LO_S);
  end

  assign entry_o = tbl_q[raddr];

  AST_TBL_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (tbl_q[$past(waddr_i)] == $past(wdata_i))); // R3
endmodule

// File: rtl/osc_code_update.sv
module osc_code_update #(
  parameter int CODE_W   = 10,
  parameter int ENTRY_W  = 11,
  parameter int NOM_CODE = 512
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic signed [ENTRY_W-1:0] entry_i,
  output logic [CODE_W-1:0]         code_o
);
  localparam int SUM_W = ((CODE_W > ENTRY_W) ? CODE_W : ENTRY_W) + 2;
  localparam logic signed [SUM_W-1:0] NOM_S = SUM_W'(NOM_CODE);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << CODE_W) - 1);

  logic signed [SUM_W-1:0] sum_s;
  logic [CODE_W-1:0]       next_code;
  logic [CODE_W-1:0]       code_q;

  always_comb begin
    sum_s = NOM_S + $signed({{(SUM_W-ENTRY_W){entry_i[ENTRY_W-1]}}, entry_i});
    if (sum_s < 0)          next_code = '0;
    else if (sum_s > MAX_S) next_code = '1;
    else                    next_code = sum_s[CODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= CODE_W'(NOM_CODE);
    else if (load_i) code_q <= next_code;
  end

  assign code_o = code_q;
endmodule

// File: rtl/osc_cal_top.sv
module osc_cal_top #(
  parameter int WIN_CYC     = 256,
  parameter int TBL_AW      = 4,
  parameter int ENTRY_W     = 11,
  parameter int CODE_W      = 10,
  parameter int NOM_CODE    = 512,
  parameter int NOM_CAL_CNT = 40,
  parameter int NOM_REF_CNT = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               osc_cal_i,
  input  logic               osc_ref_i,
  input  logic               tbl_we_i,
  input  logic [TBL_AW-1:0]  tbl_addr_i,
  input  logic [ENTRY_W-1:0] tbl_data_i,
  output logic               done_o,
  output logic [CODE_W-1:0]  code_o
);
  import osc_cal_pkg::*;

  localparam int CNT_W = $clog2(WIN_CYC + 1);

  cal_state_e                state_q, state_d;
  logic [CNT_W-1:0]          win_q;
  logic [CNT_W-1:0]          cnt_cal, cnt_ref;
  logic signed [ENTRY_W-1:0] entry_c, entry_q;
  logic                      accept, counting, load, done_q;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign counting = (state_q == ST_COUNT);
  assign load     = (state_q == ST_APPLY);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_COUNT;
      ST_COUNT: if (win_q == CNT_W'(WIN_CYC - 1)) state_d = ST_CALC;
      ST_CALC:  state_d = ST_APPLY;
      ST_APPLY: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      entry_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= load;
      if (accept)        win_q <= '0;
      else if (counting) win_q <= win_q + 1'b1;
      if (state_q == ST_CALC) entry_q <= entry_c;
    end
  end

  osc_edge_counter #(.CNT_W(CNT_W)) u_cnt_cal (
    .clk_i (clk_i), .rst_ni(rst_ni), .osc_i(osc_cal_i),
    .clr_i (accept), .en_i(counting), .cnt_o(cnt_cal)
  );

  osc_edge_counter #(.CNT_W(CNT_W)) u_cnt_ref (
    .clk_i (clk_i), .rst_ni(rst_ni), .osc_i(osc_ref_i),
    .clr_i (accept), .en_i(counting), .cnt_o(cnt_ref)
  );

  osc_diff_lut #(
    .CNT_W(CNT_W), .TBL_AW(TBL_AW), .ENTRY_W(ENTRY_W),
    .NOM_OFS(NOM_CAL_CNT - NOM_REF_CNT)
  ) u_lut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .waddr_i  (tbl_addr_i),
    .wdata_i  ($signed(tbl_data_i)),
    .cnt_cal_i(cnt_cal),
    .cnt_ref_i(cnt_ref),
    .entry_o  (entry_c)
  );

  osc_code_update #(
    .CODE_W(CODE_W), .ENTRY_W(ENTRY_W), .NOM_CODE(NOM_CODE)
  ) u_upd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .entry_i(entry_q),
    .code_o (code_o)
  );

  assign done_o = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(code_o)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> (state_q != ST_COUNT || win_q != '0)); // R7
endmodule

// File: tb/osc_cal_top_tb_top.sv
`timescale 1ns/1ps
module osc_cal_top_tb_top;
  localparam int WIN = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        osc_cal = 1'b0;
  logic        osc_ref = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_addr = '0;
  logic [10:0] tbl_data = '0;
  logic        done;
  logic [9:0]  code;

  int checks = 0;
  int fails  = 0;

  int tbl_sh [16];
  int cur_cal = 0;
  int cur_ref = 0;

  bit m_busy = 1'b0;
  int m_cnt  = 0;
  bit exp_done = 1'b0;
  int exp_code = 512;

  always #2.5 clk = ~clk;

  osc_cal_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .osc_cal_i(osc_cal), .osc_ref_i(osc_ref),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
    .done_o(done), .code_o(code)
  );

  function automatic int calc_code(int c, int r);
    int d;
    int v;
    d = (c - r) - 8;
    if (d < -8) d = -8;
    if (d > 7)  d = 7;
    v = 512 + tbl_sh[d + 8];
    if (v < 0)    v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_cnt = 0; exp_done = 1'b0; exp_code = 512;
      for (int i = 0; i < 16; i++) tbl_sh[i] = 0;
    end else begin
      exp_done = 1'b0;
      if (tbl_we) tbl_sh[tbl_addr] = $signed(tbl_data);
      if (!m_busy) begin
        if (start) begin m_busy = 1'b1; m_cnt = 0; end
      end else begin
        m_cnt++;
        if (m_cnt == WIN + 2) begin
          m_busy = 1'b0;
          exp_done = 1'b1;
          exp_code = calc_code(cur_cal, cur_ref);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 per-cycle done", int'(done), int'(exp_done));
      check("R6 per-cycle code", int'(code), exp_code);
    end
  end

  task automatic wr_tbl(input int a, input int v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(a); tbl_data = 11'(v);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic drive_osc(input bit sel, input int n);
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (sel) osc_ref = 1'b1; else osc_cal = 1'b1;
      repeat (2) @(negedge clk);
      if (sel) osc_ref = 1'b0; else osc_cal = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic run_cal(input int c, input int r, input bit mid_start, input string tag);
    int waited;
    int exp_v;
    cur_cal = c; cur_ref = r;
    exp_v = calc_code(c, r);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    waited = 1;
    fork
      drive_osc(1'b0, c);
      drive_osc(1'b1, r);
      begin
        if (mid_start) begin
          repeat (100) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    while (!done && waited < 600) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " code after done"}, int'(code), exp_v);
    repeat (5) @(negedge clk);
    check("R6 code held after done", int'(code), exp_v);
    check("R5 done dropped", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset code", int'(code), 512);
    check("R6 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cal(40, 32, 1'b0, "R1 R4 nominal, zero table");
    wr_tbl(11, 37);
    wr_tbl(0, -1000);
    wr_tbl(15, 700);
    wr_tbl(5, -45);
    run_cal(43, 32, 1'b0, "R2 R3 diff +3");
    run_cal(37, 32, 1'b0, "R2 diff -3");
    run_cal(20, 32, 1'b0, "R2 R4 low saturate and clamp to 0");
    run_cal(50, 32, 1'b0, "R2 R4 high saturate and clamp to 1023");
    run_cal(0, 40, 1'b0, "R1 R8 no cal edges gives code 0");
    run_cal(43, 32, 1'b1, "R7 start during window ignored");
    wr_tbl(11, -100);
    run_cal(43, 32, 1'b0, "R3 overwritten entry");
    run_cal(40, 32, 1'b0, "R1 back to nominal");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule